// File: doc/BRIEF.md
# I2C Bus Attach/Detach Detector

This block watches the two wires of an I2C bus and decides when a bus has been plugged onto the device or pulled away from it. Both lines high means a bus is attached and pulled up. Both low means no bus is present. A new attach or detach state is accepted only after the lines have held it for a selectable settling window. Software chooses which of the two transitions raises a sticky flag. The flag can then drive an interrupt request.

The line inputs are assumed to be already synchronised to the clock. A global interface enable gates the whole detector. A global interrupt enable and a local interrupt enable gate the request. The flag clears in two ways: software writes a one to it, or the interrupt controller pulses an acknowledge. The reset value of the flag and of the accepted bus state comes from the line levels present while reset is held.

Top module: `bus_attach_detector`

## Requirements
- R1: While `if_en` is low, no accepted transition sets the flag and `irq` is low one cycle later. The debounce logic keeps tracking the lines in this state.
- R2: The polarity bit (register bit 1) selects the event. 0 sets the flag on attach (both lines high) and 1 sets it on detach (both lines low). Mixed line levels never change the accepted bus state.
- R3: A register write with bit 7 set clears the flag. A write with bit 7 clear leaves the flag unchanged.
- R4: A one-cycle pulse on `irq_ack` clears the flag at the next clock edge.
- R5: `irq` is a registered output. It is high exactly one cycle after `if_en`, `gie`, the interrupt-enable bit (register bit 0) and the flag were all high together.
- R6: During reset, the flag and the accepted bus state are both loaded with (SDA AND SCL). A bus that stays attached through reset release therefore raises no attach event afterwards.
- R7: The debounce select field (register bits 3:2) picks 0, 16, 64 or 256 cycles for codes 0 to 3. A new level first sampled at edge k is accepted at edge k+N, where N is the selected count.
- R8: Any change on either line restarts the debounce count, so a glitch requires the full window again.
- R9: When a flag-setting event and a clear (write-one or `irq_ack`) fall on the same edge, the flag is set.
- R10: The interrupt-enable, polarity and debounce fields reset to zero. `reg_rdata` reads {flag, 3'b000, debounce[1:0], polarity, interrupt enable}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | Synchronised data line level |
| scl_in | input | 1 | Synchronised clock line level |
| if_en | input | 1 | Global interface enable |
| gie | input | 1 | Global interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| irq_ack | input | 1 | Interrupt serviced pulse, clears the flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to create from the ports is a flag-setting event landing on exactly the same edge as a clear. The stimulus first lets the lines settle at the opposite level with a zero-cycle window. It then changes the lines and asserts the write strobe, or `irq_ack`, at the same falling edge. Glitch restart is reached by holding the lines high for part of the window, dropping one line for a single cycle, and then counting the full window again. This confirms that the flag appears on the sixteenth edge after the re-raise and not earlier.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  typedef enum logic [1:0] {
    LVL_MIXED = 2'd0,
    LVL_LOW   = 2'd1,
    LVL_HIGH  = 2'd2
  } line_lvl_e;

  typedef struct packed {
    logic [1:0] db_sel;
    logic       pol;
    logic       ie;
  } bcd_cfg_t;

  localparam int IE_BIT   = 0;
  localparam int POL_BIT  = 1;
  localparam int DB_LSB   = 2;
  localparam int FLAG_BIT = 7;
  localparam int REG_W    = 8;

endpackage

// File: rtl/bcd_line_filter.sv
module bcd_line_filter
  import bcd_pkg::*;
#(
  parameter int DB1 = 16,
  parameter int DB2 = 64,
  parameter int DB3 = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda,
  input  logic       scl,
  input  logic [1:0] db_sel,
  output logic       bus_up,
  output logic       conn_evt,
  output logic       disc_evt
);

  localparam int CNT_W = $clog2(DB3 + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DB3);

  logic [1:0]       line_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] stable;
  logic [CNT_W-1:0] thr;
  logic             bus_q;
  logic             accept;
  line_lvl_e        lvl;

  // Threshold for the selected window.
  always_comb begin
    case (db_sel)
      2'd0:    thr = '0;
      2'd1:    thr = CNT_W'(DB1);
      2'd2:    thr = CNT_W'(DB2);
      default: thr = CNT_MAX;
    endcase
  end

  // Classify the current line levels.
  always_comb begin
    if (sda && scl)        lvl = LVL_HIGH;
    else if (!sda && !scl) lvl = LVL_LOW;
    else                   lvl = LVL_MIXED;
  end

  // Count of cycles the lines have held unchanged, saturating.
  always_comb begin
    if ({sda, scl} != line_q)  stable = '0;
    else if (cnt_q == CNT_MAX) stable = cnt_q;
    else                       stable = cnt_q + 1'b1;
  end

  assign accept   = (stable >= thr) &&
                    ((lvl == LVL_HIGH && !bus_q) || (lvl == LVL_LOW && bus_q));
  assign conn_evt = accept && (lvl == LVL_HIGH);
  assign disc_evt = accept && (lvl == LVL_LOW);
  assign bus_up   = bus_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= {sda, scl};
      cnt_q  <= '0;
      bus_q  <= sda & scl;
    end else begin
      line_q <= {sda, scl};
      cnt_q  <= stable;
      if (conn_evt)      bus_q <= 1'b1;
      else if (disc_evt) bus_q <= 1'b0;
    end
  end

  // R2: attach is accepted only from both lines high
  a_r2_rise_needs_high: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_q) |-> $past(sda && scl));

  // R2: detach is accepted only from both lines low
  a_r2_fall_needs_low: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_q) |-> $past(!sda && !scl));

  // R8: the hold counter never exceeds the longest window
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_MAX);

endmodule

// File: rtl/bcd_ctrl_regs.sv
module bcd_ctrl_regs
  import bcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output bcd_cfg_t         cfg,
  output logic             clr_req
);

  bcd_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr) begin
      cfg_q.ie     <= wdata[IE_BIT];
      cfg_q.pol    <= wdata[POL_BIT];
      cfg_q.db_sel <= wdata[DB_LSB+1:DB_LSB];
    end
  end

  assign cfg     = cfg_q;
  assign clr_req = wr && wdata[FLAG_BIT];

  // R10: configuration changes only through a write
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(cfg_q));

endmodule

// File: rtl/bcd_event_flag.sv
module bcd_event_flag (
  input  logic clk,
  input  logic rst,
  input  logic seed,
  input  logic if_en,
  input  logic gie,
  input  logic ie,
  input  logic pol,
  input  logic conn_evt,
  input  logic disc_evt,
  input  logic sw_clr,
  input  logic ack,
  output logic flag,
  output logic irq
);

  logic flag_q;
  logic irq_q;
  logic set_evt;

  assign set_evt = if_en && (pol ? disc_evt : conn_evt);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= seed;
      irq_q  <= 1'b0;
    end else begin
      if (set_evt)            flag_q <= 1'b1;
      else if (sw_clr || ack) flag_q <= 1'b0;
      irq_q <= if_en && gie && ie && flag_q;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;

  // R1: the flag only rises while the interface is enabled
  a_r1_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(if_en));

  // R5: a request implies all four conditions one cycle earlier
  a_r5_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(flag_q && gie && ie && if_en));

  // R4: acknowledge without a concurrent event clears the flag
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && !(if_en && (pol ? disc_evt : conn_evt))) |=> !flag_q);

  // R9: an event beats a software clear on the same edge
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (sw_clr && if_en && (pol ? disc_evt : conn_evt)) |=> flag_q);

endmodule

// File: rtl/bus_attach_detector.sv
module bus_attach_detector
  import bcd_pkg::*;
#(
  parameter int DB1 = 16,
  parameter int DB2 = 64,
  parameter int DB3 = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_in,
  input  logic             scl_in,
  input  logic             if_en,
  input  logic             gie,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             irq_ack,
  output logic             irq
);

  bcd_cfg_t cfg;
  logic     clr_req;
  logic     bus_up;
  logic     conn_evt;
  logic     disc_evt;
  logic     flag;

  bcd_ctrl_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .wdata   (reg_wdata),
    .cfg     (cfg),
    .clr_req (clr_req)
  );

  bcd_line_filter #(
    .DB1 (DB1),
    .DB2 (DB2),
    .DB3 (DB3)
  ) u_filter (
    .clk      (clk),
    .rst      (rst),
    .sda      (sda_in),
    .scl      (scl_in),
    .db_sel   (cfg.db_sel),
    .bus_up   (bus_up),
    .conn_evt (conn_evt),
    .disc_evt (disc_evt)
  );

  bcd_event_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .seed     (sda_in & scl_in),
    .if_en    (if_en),
    .gie      (gie),
    .ie       (cfg.ie),
    .pol      (cfg.pol),
    .conn_evt (conn_evt),
    .disc_evt (disc_evt),
    .sw_clr   (clr_req),
    .ack      (irq_ack),
    .flag     (flag),
    .irq      (irq)
  );

  always_comb begin
    reg_rdata                       = '0;
    reg_rdata[FLAG_BIT]             = flag;
    reg_rdata[DB_LSB+1:DB_LSB]      = cfg.db_sel;
    reg_rdata[POL_BIT]              = cfg.pol;
    reg_rdata[IE_BIT]               = cfg.ie;
  end

  // R6: after reset release, a held attached level raises no event
  a_r6_seeded_state: assert property (@(posedge clk) disable iff (rst)
    (bus_up && sda_in && scl_in) |-> !conn_evt);

endmodule

// File: tb/tb_bus_attach_detector.sv
`timescale 1ns/1ps
module tb_bus_attach_detector;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sda = 1'b0;
  logic       scl = 1'b0;
  logic       if_en = 1'b0;
  logic       gie = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       irq_ack = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] rd;
    logic       iq;
    string      tag;
  } exp_t;

  exp_t sbq[$];

  always #2.5 clk = ~clk;

  bus_attach_detector dut (
    .clk       (clk),
    .rst       (rst),
    .sda_in    (sda),
    .scl_in    (scl),
    .if_en     (if_en),
    .gie       (gie),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_ack   (irq_ack),
    .irq       (irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_exp(input logic [7:0] rd, input logic iq, input string tag);
    exp_t e;
    e.rd = rd;
    e.iq = iq;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wdata = d;
    reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic lines(input logic s, input logic c);
    sda = s;
    scl = c;
  endtask

  // Monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        n_chk++;
        if (reg_rdata !== e.rd || irq !== e.iq) begin
          n_fail++;
          $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                   e.tag, reg_rdata, irq, e.rd, e.iq);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // Driver
  initial begin
    lines(1'b0, 1'b0);
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    push_exp(8'h00, 1'b0, "R6 R10 reset with lines low");

    if_en = 1'b1;
    gie = 1'b1;
    wr(8'h01);
    push_exp(8'h01, 1'b0, "R10 register layout");

    // R2/R7: attach with zero window, R5 one cycle later
    lines(1'b1, 1'b1);
    step(1);
    push_exp(8'h81, 1'b0, "R2 R7 attach sets flag at once");
    step(1);
    push_exp(8'h81, 1'b1, "R5 irq one cycle after flag");

    // R4: acknowledge
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
    push_exp(8'h01, 1'b1, "R4 ack clears flag");
    step(1);
    push_exp(8'h01, 1'b0, "R5 irq follows flag down");

    // R2: polarity
    lines(1'b0, 1'b0);
    step(3);
    push_exp(8'h01, 1'b0, "R2 detach ignored in attach polarity");
    wr(8'h03);
    lines(1'b1, 1'b1);
    step(3);
    push_exp(8'h03, 1'b0, "R2 attach ignored in detach polarity");
    lines(1'b0, 1'b1);
    step(3);
    push_exp(8'h03, 1'b0, "R2 mixed levels keep state");
    lines(1'b0, 1'b0);
    step(1);
    push_exp(8'h83, 1'b0, "R2 detach sets flag");

    // R5: global enable gating
    gie = 1'b0;
    step(2);
    push_exp(8'h83, 1'b0, "R5 gie low blocks irq");
    gie = 1'b1;
    step(1);
    push_exp(8'h83, 1'b1, "R5 gie high raises irq");

    // R3: write zero keeps, write one clears
    wr(8'h02);
    push_exp(8'h82, 1'b1, "R3 write zero keeps flag");
    step(1);
    push_exp(8'h82, 1'b0, "R5 ie low blocks irq");
    wr(8'h82);
    push_exp(8'h02, 1'b0, "R3 write one clears flag");

    // R1: disabled interface
    if_en = 1'b0;
    lines(1'b1, 1'b1);
    step(3);
    lines(1'b0, 1'b0);
    step(3);
    push_exp(8'h02, 1'b0, "R1 no flag while disabled");
    if_en = 1'b1;
    wr(8'h03);
    lines(1'b1, 1'b1);
    step(2);
    lines(1'b0, 1'b0);
    step(1);
    push_exp(8'h83, 1'b0, "R1 detach sets flag when enabled");
    if_en = 1'b0;
    step(1);
    push_exp(8'h83, 1'b0, "R1 if_en low blocks irq");
    if_en = 1'b1;
    step(1);
    push_exp(8'h83, 1'b1, "R1 if_en high allows irq");
    wr(8'h82);
    step(1);
    push_exp(8'h02, 1'b0, "R3 clear before debounce tests");

    // R7: 16-cycle window
    wr(8'h05);
    push_exp(8'h05, 1'b0, "R7 select 16");
    lines(1'b1, 1'b1);
    step(16);
    push_exp(8'h05, 1'b0, "R7 no accept before 16");
    step(1);
    push_exp(8'h85, 1'b0, "R7 accept at 16");
    wr(8'h85);
    step(1);

    // R8: glitch restarts the count
    lines(1'b0, 1'b0);
    step(20);
    push_exp(8'h05, 1'b0, "R8 detach settles without flag");
    lines(1'b1, 1'b1);
    step(10);
    lines(1'b0, 1'b1);
    step(1);
    lines(1'b1, 1'b1);
    step(16);
    push_exp(8'h05, 1'b0, "R8 glitch restarts window");
    step(1);
    push_exp(8'h85, 1'b0, "R8 full window after glitch");

    // R7: 64-cycle window
    wr(8'h89);
    step(1);
    lines(1'b0, 1'b0);
    step(100);
    lines(1'b1, 1'b1);
    step(64);
    push_exp(8'h09, 1'b0, "R7 no accept before 64");
    step(1);
    push_exp(8'h89, 1'b0, "R7 accept at 64");

    // R7: 256-cycle window
    wr(8'h8D);
    step(1);
    lines(1'b0, 1'b0);
    step(300);
    lines(1'b1, 1'b1);
    step(256);
    push_exp(8'h0D, 1'b0, "R7 no accept before 256");
    step(1);
    push_exp(8'h8D, 1'b0, "R7 accept at 256");

    // R9: set beats write-one clear
    wr(8'h81);
    step(1);
    lines(1'b0, 1'b0);
    step(3);
    push_exp(8'h01, 1'b0, "R9 setup");
    lines(1'b1, 1'b1);
    reg_wdata = 8'h81;
    reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
    push_exp(8'h81, 1'b0, "R9 set beats write-one clear");

    // R9: set beats acknowledge
    wr(8'h83);
    step(1);
    lines(1'b0, 1'b0);
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
    push_exp(8'h83, 1'b0, "R9 set beats ack");

    // R6: reset with both lines high
    lines(1'b1, 1'b1);
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    push_exp(8'h80, 1'b0, "R6 R10 reset with lines high");
    wr(8'h81);
    step(3);
    push_exp(8'h01, 1'b0, "R6 seeded bus state gives no attach event");

    step(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule